// File: doc/BRIEF.md
# Asynchronous Serial Port with Software Ninth Bit

This block is a full-duplex asynchronous serial port. It sends and receives frames in one of two formats, chosen by a mode input. In the nine-bit format, each frame carries eight data bits and one extra data bit. In the eight-bit format, each frame carries only the eight data bits. On transmit, the extra bit comes from a software-held control input, so it can serve as a parity bit or as an address marker. On receive, the extra bit is latched next to the received byte. In the eight-bit format, that same status bit latches the received stop bit instead.

An external rate generator supplies the base tick, `baudTick`. Internally the block turns this into a sixteen-times oversampling tick. When `dblRate` is clear, the block uses every other base tick. When `dblRate` is set, it uses every base tick, which doubles the line rate. Software sees three groups of state. The completion flags are set by hardware and cleared only by pulse inputs. The receive data register and its extra bit are held until the next accepted frame. A multiprocessor filter lets a receiver ignore frames that are not marked as addresses.

Top module: `serial_port9`

## Requirements
- R1: In nine-bit mode (`modeNine`=1), a transmitted frame has these bits in order: a start bit of 0, the eight bits of `txByte` least significant first, the value of `txNinth` captured at the write, and a stop bit of 1. Each bit lasts 16 oversampling ticks. The line goes low on the clock after `txWr`.
- R2: In eight-bit mode (`modeNine`=0), a transmitted frame has a start bit of 0, the eight data bits least significant first, and a stop bit of 1. No extra bit is sent.
- R3: The oversampling tick happens on every second `baudTick` when `dblRate`=0, and on every `baudTick` when `dblRate`=1. With `dblRate`=1, each bit lasts half as many clocks. The phase of the divide-by-two counter starts at 0 after reset.
- R4: `txDone` is set on the clock that ends the stop bit. It stays set until `clrTxDone` is pulsed. A `txWr` issued while a frame is being sent is ignored.
- R5: In nine-bit mode with `mpEn`=0, a received frame loads `rxData` with the eight data bits, loads `rxNinth` with the received extra bit, and sets `rxDone`. `rxDone` clears only on `clrRxDone`.
- R6: In eight-bit mode with `mpEn`=0, `rxNinth` takes the received stop bit. The frame is accepted even when the stop bit is 0.
- R7: While `rxEn`=0, no frame is received: `rxDone`, `rxData` and `rxNinth` are left unchanged.
- R8: In nine-bit mode with `mpEn`=1, a frame is accepted only when its received extra bit is 1.
- R9: In eight-bit mode with `mpEn`=1, a frame is accepted only when its stop bit is 1.
- R10: While `rxDone` is set, a newly received frame is discarded, and `rxData` and `rxNinth` keep their values.
- R11: Each received bit is the majority of oversampling samples 7, 8 and 9, counted from the tick that saw the line low. A start bit whose vote is 1 is rejected, and the receiver returns to idle.
- R12: After reset, `txLine` is 1, both flags are 0, and `rxData` and `rxNinth` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| baudTick | input | 1 | Base rate tick from the external generator |
| dblRate | input | 1 | 1 = use every base tick (double rate) |
| modeNine | input | 1 | 1 = nine-bit frame, 0 = eight-bit frame |
| mpEn | input | 1 | Multiprocessor address filter enable |
| rxEn | input | 1 | Receiver enable |
| txNinth | input | 1 | Extra bit to transmit in nine-bit mode |
| txWr | input | 1 | Write strobe for the transmit byte; starts a frame when idle |
| txByte | input | 8 | Transmit data |
| clrTxDone | input | 1 | Clears the transmit-complete flag |
| clrRxDone | input | 1 | Clears the receive-complete flag |
| rxIn | input | 1 | Serial receive line |
| txLine | output | 1 | Serial transmit line |
| txDone | output | 1 | Transmit-complete flag |
| rxDone | output | 1 | Receive-complete flag |
| rxData | output | 8 | Last accepted received byte |
| rxNinth | output | 1 | Received extra bit, or stop bit in eight-bit mode |

## Verification
The properties assume the following about the inputs:
- `clrTxDone` and `clrRxDone` are the only ways software removes a flag.
- `modeNine`, `mpEn` and `dblRate` are not changed while a frame is in flight.
- `rxIn` holds each bit steady across the voting window.

The stimulus changes configuration only while both directions are idle. It drives every received bit for a whole bit time. It raises a clear pulse only when no completion can land in the same cycle. The one deliberately short low pulse on `rxIn` is the start-bit glitch, which is used to check that a start bit is rejected.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic txFinish;
    logic rxGrabA;
    logic rxGrabB;
    logic rxShift;
    logic rxFinish;
  } spStrobe_t;
endpackage

// File: rtl/sp_ctrl.sv
module sp_ctrl
  import sp_pkg::*;
#(
  parameter int OS_RATE = 16,
  parameter int DATA_W  = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      osTick,
  input  logic      modeNine,
  input  logic      rxEn,
  input  logic      txWr,
  input  logic      rxS,
  input  logic      vote,
  output spStrobe_t stb
);
  localparam int OSW = $clog2(OS_RATE);
  localparam int BW  = $clog2(DATA_W + 3);
  localparam logic [OSW-1:0] OS_LAST = OSW'(OS_RATE - 1);
  localparam logic [OSW-1:0] MID     = OSW'(OS_RATE / 2);

  logic           txBusy, rxBusy;
  logic [OSW-1:0] txOs, rxOs;
  logic [BW-1:0]  txBit, rxBit, lastBit;

  // index of the stop bit in the frame
  assign lastBit = modeNine ? BW'(DATA_W + 2) : BW'(DATA_W + 1);

  always_comb begin
    stb = '0;
    stb.txLoad = txWr && !txBusy;
    if (txBusy && osTick && txOs == OS_LAST) begin
      if (txBit == lastBit) stb.txFinish = 1'b1;
      else                  stb.txShift  = 1'b1;
    end
    if (rxBusy && rxEn && osTick) begin
      stb.rxGrabA = (rxOs == MID - 1'b1);
      stb.rxGrabB = (rxOs == MID);
      if (rxOs == MID + 1'b1 && rxBit != '0) begin
        if (rxBit == lastBit) stb.rxFinish = 1'b1;
        else                  stb.rxShift  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txOs   <= '0;
      txBit  <= '0;
    end else if (stb.txLoad) begin
      txBusy <= 1'b1;
      txOs   <= '0;
      txBit  <= '0;
    end else if (txBusy && osTick) begin
      txOs <= (txOs == OS_LAST) ? '0 : txOs + 1'b1;
      if (txOs == OS_LAST) begin
        if (txBit == lastBit) txBusy <= 1'b0;
        else                  txBit  <= txBit + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBusy <= 1'b0;
      rxOs   <= '0;
      rxBit  <= '0;
    end else if (!rxBusy) begin
      if (osTick && rxEn && !rxS) begin
        rxBusy <= 1'b1;
        rxOs   <= OSW'(1);
        rxBit  <= '0;
      end
    end else if (!rxEn) begin
      rxBusy <= 1'b0;
    end else if (osTick) begin
      rxOs <= (rxOs == OS_LAST) ? '0 : rxOs + 1'b1;
      if (rxOs == MID + 1'b1) begin
        if ((rxBit == '0 && vote) || rxBit == lastBit) rxBusy <= 1'b0;
        else                                           rxBit  <= rxBit + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sp_dp.sv
module sp_dp
  import sp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spStrobe_t         stb,
  input  logic              baudTick,
  input  logic              dblRate,
  input  logic              modeNine,
  input  logic              mpEn,
  input  logic              txNinth,
  input  logic [DATA_W-1:0] txByte,
  input  logic              clrTxDone,
  input  logic              clrRxDone,
  input  logic              rxIn,
  output logic              osTick,
  output logic              rxS,
  output logic              vote,
  output logic              txLine,
  output logic              txDone,
  output logic              rxDone,
  output logic [DATA_W-1:0] rxData,
  output logic              rxNinth
);
  localparam int TXW = DATA_W + 3;

  logic           phase, sA, sB, accept;
  logic [1:0]     rxSync;
  logic [DATA_W:0] rxSh;
  logic [TXW-1:0] txSh;

  assign osTick = baudTick && (dblRate || phase);
  assign rxS    = rxSync[1];
  assign vote   = (sA & sB) | (sA & rxS) | (sB & rxS);
  assign txLine = txSh[0];
  assign accept = !rxDone && (!mpEn || (modeNine ? rxSh[DATA_W] : vote));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= 1'b0;
      rxSync <= 2'b11;
      sA     <= 1'b1;
      sB     <= 1'b1;
    end else begin
      if (baudTick) phase <= !phase;
      rxSync <= {rxSync[0], rxIn};
      if (stb.rxGrabA) sA <= rxS;
      if (stb.rxGrabB) sB <= rxS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh   <= '1;
      txDone <= 1'b0;
    end else begin
      if (stb.txLoad)
        txSh <= modeNine ? {1'b1, txNinth, txByte, 1'b0} : {2'b11, txByte, 1'b0};
      else if (stb.txShift)
        txSh <= {1'b1, txSh[TXW-1:1]};
      else if (stb.txFinish)
        txSh <= '1;
      if (stb.txFinish)  txDone <= 1'b1;
      else if (clrTxDone) txDone <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh    <= '0;
      rxDone  <= 1'b0;
      rxData  <= '0;
      rxNinth <= 1'b0;
    end else begin
      if (stb.rxShift) rxSh <= {vote, rxSh[DATA_W:1]};
      if (stb.rxFinish && accept) begin
        rxDone  <= 1'b1;
        rxData  <= modeNine ? rxSh[DATA_W-1:0] : rxSh[DATA_W:1];
        rxNinth <= modeNine ? rxSh[DATA_W] : vote;
      end else if (clrRxDone) begin
        rxDone <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_port9.sv
module serial_port9
  import sp_pkg::*;
#(
  parameter int OS_RATE = 16,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              dblRate,
  input  logic              modeNine,
  input  logic              mpEn,
  input  logic              rxEn,
  input  logic              txNinth,
  input  logic              txWr,
  input  logic [DATA_W-1:0] txByte,
  input  logic              clrTxDone,
  input  logic              clrRxDone,
  input  logic              rxIn,
  output logic              txLine,
  output logic              txDone,
  output logic              rxDone,
  output logic [DATA_W-1:0] rxData,
  output logic              rxNinth
);
  spStrobe_t stb;
  logic      osTick, rxS, vote;

  sp_ctrl #(.OS_RATE(OS_RATE), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .osTick(osTick), .modeNine(modeNine),
    .rxEn(rxEn), .txWr(txWr), .rxS(rxS), .vote(vote), .stb(stb)
  );

  sp_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .baudTick(baudTick),
    .dblRate(dblRate), .modeNine(modeNine), .mpEn(mpEn),
    .txNinth(txNinth), .txByte(txByte), .clrTxDone(clrTxDone),
    .clrRxDone(clrRxDone), .rxIn(rxIn), .osTick(osTick), .rxS(rxS),
    .vote(vote), .txLine(txLine), .txDone(txDone), .rxDone(rxDone),
    .rxData(rxData), .rxNinth(rxNinth)
  );
endmodule

// File: rtl/sp_chk.sv
module sp_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEn,
  input logic              clrTxDone,
  input logic              clrRxDone,
  input logic              txLine,
  input logic              txDone,
  input logic              rxDone,
  input logic [DATA_W-1:0] rxData,
  input logic              rxNinth
);
  // R4
  tx_flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txDone) |-> $past(clrTxDone));

  // R1
  tx_idle_at_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txDone) |-> txLine);

  // R5
  rx_flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxDone) |-> $past(clrRxDone));

  // R7
  rx_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDone) |-> $past(rxEn));

  // R10
  rx_hold_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && $past(rxDone)) |-> ($stable(rxData) && $stable(rxNinth)));
endmodule

bind serial_port9 sp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .rxEn(rxEn), .clrTxDone(clrTxDone),
  .clrRxDone(clrRxDone), .txLine(txLine), .txDone(txDone),
  .rxDone(rxDone), .rxData(rxData), .rxNinth(rxNinth)
);

// File: tb/sim_serial_port9.sv
`timescale 1ns/1ps
module sim_serial_port9;
  logic clk = 0, rstN = 0, baudTick = 0, dblRate = 0, modeNine = 1, mpEn = 0;
  logic rxEn = 1, txNinth = 0, txWr = 0, clrTxDone = 0, clrRxDone = 0, rxIn = 1;
  logic [7:0] txByte = 0;
  logic txLine, txDone, rxDone, rxNinth;
  logic [7:0] rxData;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  // behavioural transmit reference
  bit mPhase = 0, mBusy = 0, mLine = 1, mTxDone = 0;
  int mOs = 0, mIdx = 0;
  bit mBits[$];

  always #4 clk = ~clk;

  serial_port9 u0 (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .dblRate(dblRate),
    .modeNine(modeNine), .mpEn(mpEn), .rxEn(rxEn), .txNinth(txNinth),
    .txWr(txWr), .txByte(txByte), .clrTxDone(clrTxDone),
    .clrRxDone(clrRxDone), .rxIn(rxIn), .txLine(txLine), .txDone(txDone),
    .rxDone(rxDone), .rxData(rxData), .rxNinth(rxNinth)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  endtask

  // R1 R2 R3 R4: model updated at the same edges the design uses
  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mBusy = 0; mLine = 1; mTxDone = 0;
    end else begin
      bit os;
      os = baudTick && (dblRate || mPhase);
      if (baudTick) mPhase = !mPhase;
      if (clrTxDone) mTxDone = 0;
      if (txWr && !mBusy) begin
        mBits.delete();
        mBits.push_back(0);
        for (int i = 0; i < 8; i++) mBits.push_back(txByte[i]);
        if (modeNine) mBits.push_back(txNinth);
        mBits.push_back(1);
        mBusy = 1; mOs = 0; mIdx = 0; mLine = 0;
      end else if (mBusy && os) begin
        if (mOs == 15) begin
          mOs = 0;
          if (mIdx == mBits.size() - 1) begin
            mBusy = 0; mLine = 1; mTxDone = 1;
          end else begin
            mIdx++; mLine = mBits[mIdx];
          end
        end else mOs++;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R1/R2/R3", "txLine vs model", txLine, mLine);
      check("R4", "txDone vs model", txDone, mTxDone);
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      baudTick = ~baudTick;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic send_tx(input logic [7:0] d);
    @(negedge clk); txByte = d; txWr = 1;
    @(negedge clk); txWr = 0;
  endtask

  task automatic wait_tx();
    while (mBusy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_clr_rx();
    @(negedge clk); clrRxDone = 1;
    @(negedge clk); clrRxDone = 0;
  endtask

  task automatic send_rx(input logic [7:0] d, input bit ninth, input bit stopv);
    int bitClk;
    bitClk = dblRate ? 32 : 64;
    rxIn = 0; repeat (bitClk) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxIn = d[i]; repeat (bitClk) @(negedge clk);
    end
    if (modeNine) begin rxIn = ninth; repeat (bitClk) @(negedge clk); end
    rxIn = stopv; repeat (bitClk) @(negedge clk);
    rxIn = 1; repeat (2 * bitClk) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", "txLine", txLine, 1);
    check("R12", "txDone", txDone, 0);
    check("R12", "rxDone", rxDone, 0);
    check("R12", "rxData", rxData, 0);
    check("R12", "rxNinth", rxNinth, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R1 nine-bit frame, R4 write while busy ignored
    modeNine = 1; txNinth = 1;
    send_tx(8'hA5);
    repeat (100) @(negedge clk);
    txNinth = 0;
    send_tx(8'h3C);
    wait_tx();
    check("R4", "txDone after frame", txDone, 1);
    check("R4", "line idle", txLine, 1);
    @(negedge clk); clrTxDone = 1; @(negedge clk); clrTxDone = 0;
    check("R4", "txDone cleared", txDone, 0);
    // R2 eight-bit frame
    modeNine = 0;
    send_tx(8'h5A);
    wait_tx();
    check("R2", "txDone eight-bit", txDone, 1);
    @(negedge clk); clrTxDone = 1; @(negedge clk); clrTxDone = 0;
    // R3 doubled rate
    dblRate = 1; modeNine = 1; txNinth = 0;
    send_tx(8'hC3);
    wait_tx();
    check("R3", "txDone doubled", txDone, 1);
    @(negedge clk); clrTxDone = 1; @(negedge clk); clrTxDone = 0;
    dblRate = 0;

    // R5 nine-bit receive
    modeNine = 1; mpEn = 0;
    send_rx(8'h96, 0, 1);
    check("R5", "rxDone", rxDone, 1);
    check("R5", "rxData", rxData, 8'h96);
    check("R5", "rxNinth", rxNinth, 0);
    pulse_clr_rx();
    check("R5", "rxDone cleared", rxDone, 0);
    send_rx(8'h01, 1, 1);
    check("R5", "rxNinth one", rxNinth, 1);
    pulse_clr_rx();

    // R6 eight-bit: ninth holds stop bit
    modeNine = 0;
    send_rx(8'h3B, 0, 0);
    check("R6", "rxDone bad stop", rxDone, 1);
    check("R6", "rxData", rxData, 8'h3B);
    check("R6", "rxNinth=stop 0", rxNinth, 0);
    pulse_clr_rx();
    send_rx(8'h11, 0, 1);
    check("R6", "rxNinth=stop 1", rxNinth, 1);
    check("R6", "rxData", rxData, 8'h11);
    pulse_clr_rx();

    // R7 receiver disabled
    rxEn = 0;
    send_rx(8'hEE, 0, 1);
    check("R7", "rxDone disabled", rxDone, 0);
    check("R7", "rxData kept", rxData, 8'h11);
    rxEn = 1;

    // R8 nine-bit address filter
    modeNine = 1; mpEn = 1;
    send_rx(8'h42, 0, 1);
    check("R8", "data frame filtered", rxDone, 0);
    check("R8", "rxData kept", rxData, 8'h11);
    send_rx(8'h24, 1, 1);
    check("R8", "address accepted", rxDone, 1);
    check("R8", "rxData", rxData, 8'h24);
    pulse_clr_rx();

    // R9 eight-bit filter on stop bit
    modeNine = 0;
    send_rx(8'h81, 0, 0);
    check("R9", "bad stop filtered", rxDone, 0);
    send_rx(8'h18, 0, 1);
    check("R9", "good stop accepted", rxDone, 1);
    check("R9", "rxData", rxData, 8'h18);

    // R10 flag still set blocks a new frame
    mpEn = 0;
    send_rx(8'h77, 0, 0);
    check("R10", "rxData held", rxData, 8'h18);
    check("R10", "rxNinth held", rxNinth, 1);
    pulse_clr_rx();

    // R11 short start pulse rejected
    modeNine = 1;
    rxIn = 0; repeat (8) @(negedge clk); rxIn = 1;
    repeat (200) @(negedge clk);
    check("R11", "glitch rejected", rxDone, 0);
    send_rx(8'h5C, 1, 1);
    check("R11", "frame after glitch", rxData, 8'h5C);
    check("R11", "ninth after glitch", rxNinth, 1);
    pulse_clr_rx();

    // R3 receive at doubled rate
    dblRate = 1;
    send_rx(8'hB7, 0, 1);
    check("R3", "rx doubled done", rxDone, 1);
    check("R3", "rx doubled data", rxData, 8'hB7);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule